// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block manages one directory entry of a cache-coherent system. The entry holds a small, fixed number of exact sharer pointers instead of one presence bit per node. Requests arrive one at a time on a valid/ready channel. Each request names a node and is either a read, which adds that node as a sharer, or a write, which makes that node the sole holder. The block answers with a stream of node IDs to invalidate, one per cycle, on a second valid/ready channel.

When more distinct readers arrive than there are pointer slots, the entry overflows. A parameter selects one of three behaviours for that case. Broadcast mode sets the overflow flag, and a later write invalidates every node. Eviction mode displaces one recorded sharer, chosen round-robin, and sends an invalidation to the displaced node. Coarse mode reinterprets the pointer storage as a coarse bit vector in which each bit stands for a group of adjacent nodes. The current entry contents are visible on plain status pins.

Back-pressure rules: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The request fields are sampled only on that cycle. `req_ready` stays low while any invalidation of the previous request is still pending. An invalidation transfers on a cycle where `inv_valid` and `inv_ready` are both high. While `inv_valid` is high and `inv_ready` is low, `inv_node` holds its value.

Top module: `dir_limited_ptr`

## Requirements
- R1: After reset the entry is empty: `ent_count` = 0, `ent_ovf` = 0, `ent_bits` = 0, `req_ready` = 1 and `inv_valid` = 0.
- R2: A read by a node that is not yet recorded, while a slot is free, stores the node in slot `ent_count` and increments `ent_count`. Slot s occupies `ent_bits[s*ID_W +: ID_W]`.
- R3: A read by a node that is already recorded leaves `ent_bits`, `ent_count` and `ent_ovf` unchanged and produces no invalidation.
- R4: A write invalidates every recorded sharer other than the writer. The IDs are streamed in ascending order, each exactly once, one per handshake. A write by the only recorded node produces no invalidation.
- R5: After a write, the entry holds only the writer: `ent_count` = 1, slot 0 = writer, all other storage bits 0, and `ent_ovf` = 0.
- R6: In broadcast mode, a read by a new node while all slots are full sets `ent_ovf` and leaves `ent_bits` unchanged. Once set, `ent_ovf` stays set until a write. A write under overflow invalidates every node except the writer.
- R7: In eviction mode, a read by a new node while all slots are full overwrites slot `rr` and invalidates only the node that was in that slot. `rr` starts at 0 after reset and after every write, and advances by one modulo the slot count on each replacement. `ent_ovf` stays 0.
- R8: In coarse mode, a read by a new node while all slots are full sets `ent_ovf` and rewrites `ent_bits` as a group vector. Bit g is set when any recorded node or the new node lies in nodes g*GROUP to g*GROUP+GROUP-1, where GROUP = ceil(NODES/(PTRS*ID_W)). Later reads set the bit of the reader's group.
- R9: In coarse mode, a write under overflow invalidates every node of each group whose bit is set, except the writer.
- R10: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high, `inv_node` is stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read (add sharer) |
| req_node | input | ID_W | Requesting node |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Consumer takes the invalidation |
| inv_node | output | ID_W | Node to invalidate |
| ent_ovf | output | 1 | Entry is in overflow form |
| ent_count | output | CNT_W | Number of occupied pointer slots |
| ent_bits | output | PTRS*ID_W | Pointer slots, or the group vector under overflow |

## Verification
The bench builds three copies, one per overflow mode, each with 16 nodes and 2 pointers, so each has 8 storage bits and a group size of two. All three receive the same request sequence. This lets one sequence compare broadcast, eviction and coarse results side by side. It reaches the round-robin wrap of the eviction slot, an all-but-writer broadcast of 15 IDs, and a coarse conversion built from both existing pointers and the new reader. The stall test holds `inv_ready` low across a long broadcast drain.

// File: rtl/dir_ptr_pkg.sv
package dir_ptr_pkg;
  typedef enum logic [1:0] {
    OVF_BCAST  = 2'd0,
    OVF_EVICT  = 2'd1,
    OVF_COARSE = 2'd2
  } ovf_mode_e;
endpackage

// File: rtl/dir_sharer_decode.sv
module dir_sharer_decode
  import dir_ptr_pkg::*;
#(
  parameter int        NODES   = 16,
  parameter int        PTRS    = 2,
  parameter int        ID_W    = 4,
  parameter int        CNT_W   = 2,
  parameter int        GROUP   = 2,
  parameter ovf_mode_e MODE    = OVF_COARSE,
  localparam int       STORE_W = PTRS * ID_W
) (
  input  logic               ovf,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [STORE_W-1:0] bits,
  output logic [NODES-1:0]   mask
);
  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [PTRS-1:0] hit;
    for (genvar p = 0; p < PTRS; p++) begin : g_slot
      assign hit[p] = (CNT_W'(p) < cnt) && (bits[p*ID_W +: ID_W] == ID_W'(n));
    end
    if (MODE == OVF_BCAST) begin : g_bc
      assign mask[n] = ovf | (|hit);
    end else if (MODE == OVF_COARSE) begin : g_cv
      assign mask[n] = ovf ? bits[n/GROUP] : (|hit);
    end else begin : g_ev
      assign mask[n] = |hit;
    end
  end
endmodule

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl
  import dir_ptr_pkg::*;
#(
  parameter int        NODES   = 16,
  parameter int        PTRS    = 2,
  parameter int        ID_W    = 4,
  parameter int        CNT_W   = 2,
  parameter int        GROUP   = 2,
  parameter ovf_mode_e MODE    = OVF_COARSE,
  localparam int       STORE_W = PTRS * ID_W,
  localparam int       RR_W    = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               wr,
  input  logic [ID_W-1:0]    node,
  input  logic [NODES-1:0]   mask,
  output logic               ovf_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [STORE_W-1:0] bits_q,
  output logic [NODES-1:0]   inv_load
);
  logic               ovf_d;
  logic [CNT_W-1:0]   cnt_d;
  logic [STORE_W-1:0] bits_d;
  logic [RR_W-1:0]    rr_q, rr_d;
  logic [NODES-1:0]   node_oh, merged;
  logic [STORE_W-1:0] grp_all, grp_new;

  assign node_oh = NODES'(1) << node;
  assign merged  = mask | node_oh;

  for (genvar g = 0; g < STORE_W; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = (LO + GROUP > NODES) ? NODES - 1 : LO + GROUP - 1;
    if (LO < NODES) begin : g_live
      assign grp_all[g] = |merged[HI:LO];
      assign grp_new[g] = |node_oh[HI:LO];
    end else begin : g_dead
      assign grp_all[g] = 1'b0;
      assign grp_new[g] = 1'b0;
    end
  end

  always_comb begin
    ovf_d    = ovf_q;
    cnt_d    = cnt_q;
    bits_d   = bits_q;
    rr_d     = rr_q;
    inv_load = '0;
    if (acc) begin
      if (wr) begin
        inv_load           = mask & ~node_oh;
        ovf_d              = 1'b0;
        cnt_d              = CNT_W'(1);
        bits_d             = '0;
        bits_d[ID_W-1:0]   = node;
        rr_d               = '0;
      end else if (ovf_q) begin
        if (MODE == OVF_COARSE) bits_d = bits_q | grp_new;
      end else if (!(|(mask & node_oh))) begin
        if (cnt_q < CNT_W'(PTRS)) begin
          for (int p = 0; p < PTRS; p++)
            if (cnt_q == CNT_W'(p)) bits_d[p*ID_W +: ID_W] = node;
          cnt_d = cnt_q + CNT_W'(1);
        end else if (MODE == OVF_EVICT) begin
          for (int p = 0; p < PTRS; p++) begin
            if (rr_q == RR_W'(p)) begin
              inv_load                = NODES'(1) << bits_q[p*ID_W +: ID_W];
              bits_d[p*ID_W +: ID_W]  = node;
            end
          end
          rr_d = (rr_q == RR_W'(PTRS - 1)) ? '0 : rr_q + RR_W'(1);
        end else if (MODE == OVF_COARSE) begin
          ovf_d  = 1'b1;
          bits_d = grp_all;
        end else begin
          ovf_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      bits_q <= '0;
      rr_q   <= '0;
    end else begin
      ovf_q  <= ovf_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      rr_q   <= rr_d;
    end
  end
endmodule

// File: rtl/dir_inval_stream.sv
module dir_inval_stream #(
  parameter int NODES = 16,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [NODES-1:0] load_mask,
  input  logic             inv_ready,
  output logic             inv_valid,
  output logic [ID_W-1:0]  inv_node
);
  logic [NODES-1:0] pend_q;

  assign inv_valid = |pend_q;

  always_comb begin
    inv_node = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (pend_q[n]) inv_node = ID_W'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= '0;
    else if (load_en)                pend_q <= load_mask;
    else if (inv_valid && inv_ready) pend_q <= pend_q & (pend_q - NODES'(1));
  end
endmodule

// File: rtl/dir_limited_ptr.sv
module dir_limited_ptr
  import dir_ptr_pkg::*;
#(
  parameter int        NODES   = 16,
  parameter int        PTRS    = 2,
  parameter ovf_mode_e MODE    = OVF_COARSE,
  localparam int       ID_W    = $clog2(NODES),
  localparam int       CNT_W   = $clog2(PTRS + 1),
  localparam int       STORE_W = PTRS * ID_W,
  localparam int       GROUP   = (NODES + STORE_W - 1) / STORE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ID_W-1:0]    req_node,
  output logic               inv_valid,
  input  logic               inv_ready,
  output logic [ID_W-1:0]    inv_node,
  output logic               ent_ovf,
  output logic [CNT_W-1:0]   ent_count,
  output logic [STORE_W-1:0] ent_bits
);
  logic             acc;
  logic [NODES-1:0] sharers, inv_load;

  assign req_ready = !inv_valid;
  assign acc       = req_valid && req_ready;

  dir_sharer_decode #(
    .NODES(NODES), .PTRS(PTRS), .ID_W(ID_W), .CNT_W(CNT_W), .GROUP(GROUP), .MODE(MODE)
  ) u_decode (
    .ovf (ent_ovf),
    .cnt (ent_count),
    .bits(ent_bits),
    .mask(sharers)
  );

  dir_entry_ctrl #(
    .NODES(NODES), .PTRS(PTRS), .ID_W(ID_W), .CNT_W(CNT_W), .GROUP(GROUP), .MODE(MODE)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .wr      (req_write),
    .node    (req_node),
    .mask    (sharers),
    .ovf_q   (ent_ovf),
    .cnt_q   (ent_count),
    .bits_q  (ent_bits),
    .inv_load(inv_load)
  );

  dir_inval_stream #(
    .NODES(NODES), .ID_W(ID_W)
  ) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (acc),
    .load_mask(inv_load),
    .inv_ready(inv_ready),
    .inv_valid(inv_valid),
    .inv_node (inv_node)
  );
endmodule

// File: rtl/dir_limited_ptr_chk.sv
module dir_limited_ptr_chk #(
  parameter int  NODES   = 16,
  parameter int  PTRS    = 2,
  localparam int ID_W    = $clog2(NODES),
  localparam int CNT_W   = $clog2(PTRS + 1),
  localparam int STORE_W = PTRS * ID_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [ID_W-1:0]    req_node,
  input logic               inv_valid,
  input logic               inv_ready,
  input logic [ID_W-1:0]    inv_node,
  input logic               ent_ovf,
  input logic [CNT_W-1:0]   ent_count,
  input logic [STORE_W-1:0] ent_bits
);
  logic            wr_seen;
  logic [ID_W-1:0] last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      last_w  <= '0;
    end else if (req_valid && req_ready) begin
      wr_seen <= req_write;
      last_w  <= req_node;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_node)); // R10

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready |=> !inv_valid || (inv_node > $past(inv_node))); // R4

  AST_SKIP_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && wr_seen |-> inv_node != last_w); // R4

  AST_WRITE_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=>
      ent_count == CNT_W'(1) && !ent_ovf && ent_bits[ID_W-1:0] == $past(req_node)); // R5

  AST_READ_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> ent_count >= $past(ent_count)); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && ent_ovf |=> ent_ovf); // R6
endmodule

bind dir_limited_ptr dir_limited_ptr_chk #(.NODES(NODES), .PTRS(PTRS)) u_chk (.*);

// File: tb/test_dir_limited_ptr.sv
`timescale 1ns/1ps
module test_dir_limited_ptr;
  import dir_ptr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, inv_ready = 1'b1;
  logic [3:0] req_node = '0;

  logic       bc_rdy, nb_rdy, cv_rdy, bc_iv, nb_iv, cv_iv, bc_ovf, nb_ovf, cv_ovf;
  logic [3:0] bc_in, nb_in, cv_in;
  logic [1:0] bc_cnt, nb_cnt, cv_cnt;
  logic [7:0] bc_bits, nb_bits, cv_bits;

  int n_chk = 0, n_fail = 0;
  logic [15:0] log_bc, log_nb, log_cv;
  int last_bc, last_nb, last_cv;

  always #10 clk = ~clk;

  dir_limited_ptr #(.NODES(16), .PTRS(2), .MODE(OVF_COARSE)) i_dir_limited_ptr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(cv_rdy),
    .req_write(req_write), .req_node(req_node), .inv_valid(cv_iv), .inv_ready(inv_ready),
    .inv_node(cv_in), .ent_ovf(cv_ovf), .ent_count(cv_cnt), .ent_bits(cv_bits));

  dir_limited_ptr #(.NODES(16), .PTRS(2), .MODE(OVF_BCAST)) i_dir_limited_ptr_bc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(bc_rdy),
    .req_write(req_write), .req_node(req_node), .inv_valid(bc_iv), .inv_ready(inv_ready),
    .inv_node(bc_in), .ent_ovf(bc_ovf), .ent_count(bc_cnt), .ent_bits(bc_bits));

  dir_limited_ptr #(.NODES(16), .PTRS(2), .MODE(OVF_EVICT)) i_dir_limited_ptr_nb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(nb_rdy),
    .req_write(req_write), .req_node(req_node), .inv_valid(nb_iv), .inv_ready(inv_ready),
    .inv_node(nb_in), .ent_ovf(nb_ovf), .ent_count(nb_cnt), .ent_bits(nb_bits));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // invalidation monitors: log each ID, check ascending and no repeats (R4)
  always @(posedge clk) begin
    if (bc_iv && inv_ready) begin
      if (int'(bc_in) <= last_bc) chk("R4 bc order", {28'd0, bc_in}, last_bc + 1);
      last_bc = int'(bc_in); log_bc[bc_in] = 1'b1;
    end
    if (nb_iv && inv_ready) begin
      if (int'(nb_in) <= last_nb) chk("R4 nb order", {28'd0, nb_in}, last_nb + 1);
      last_nb = int'(nb_in); log_nb[nb_in] = 1'b1;
    end
    if (cv_iv && inv_ready) begin
      if (int'(cv_in) <= last_cv) chk("R4 cv order", {28'd0, cv_in}, last_cv + 1);
      last_cv = int'(cv_in); log_cv[cv_in] = 1'b1;
    end
  end

  task automatic clear_logs();
    log_bc = '0; log_nb = '0; log_cv = '0;
    last_bc = -1; last_nb = -1; last_cv = -1;
  endtask

  task automatic wait_idle();
    while (!(bc_rdy && nb_rdy && cv_rdy)) @(negedge clk);
  endtask

  task automatic issue(input logic wr, input logic [3:0] nd);
    wait_idle();
    clear_logs();
    req_valid = 1'b1; req_write = wr; req_node = nd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_op(input logic wr, input logic [3:0] nd);
    issue(wr, nd);
    wait_idle();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [3:0]  node;
    logic [15:0] bc;
    logic [15:0] nb;
    logic [15:0] cv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3,  16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 4'd3,  16'h0000, 16'h0000, 16'h0000},  // duplicate, R3
    '{1'b0, 4'd9,  16'h0000, 16'h0000, 16'h0000},
    '{1'b1, 4'd9,  16'h0008, 16'h0008, 16'h0008},  // R4
    '{1'b0, 4'd4,  16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 4'd12, 16'h0000, 16'h0200, 16'h0000},  // overflow, R6 R7 R8
    '{1'b0, 4'd5,  16'h0000, 16'h0010, 16'h0000},
    '{1'b0, 4'd0,  16'h0000, 16'h1000, 16'h0000},  // rr wraps, R7
    '{1'b1, 4'd8,  16'hFEFF, 16'h0021, 16'h3233},  // R6 R9
    '{1'b1, 4'd8,  16'h0000, 16'h0000, 16'h0000},  // writer alone, R4
    '{1'b1, 4'd2,  16'h0100, 16'h0100, 16'h0100},
    '{1'b0, 4'd7,  16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 4'd7,  16'h0000, 16'h0000, 16'h0000},  // duplicate when full, R3
    '{1'b1, 4'd2,  16'h0080, 16'h0080, 16'h0080}
  };

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk("R1 cv count", {30'd0, cv_cnt}, 0);
    chk("R1 cv ovf/ready/valid", {29'd0, cv_ovf, cv_rdy, cv_iv}, 32'b010);
    chk("R1 bc ovf/ready/valid", {29'd0, bc_ovf, bc_rdy, bc_iv}, 32'b010);
    chk("R1 nb bits", {24'd0, nb_bits}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cv bits after release", {24'd0, cv_bits}, 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].wr, VECS[i].node);
      chk($sformatf("R4 R6 bc step %0d", i), {16'd0, log_bc}, {16'd0, VECS[i].bc});
      chk($sformatf("R4 R7 nb step %0d", i), {16'd0, log_nb}, {16'd0, VECS[i].nb});
      chk($sformatf("R4 R9 cv step %0d", i), {16'd0, log_cv}, {16'd0, VECS[i].cv});
    end

    // R5 entry holds only the last writer (node 2)
    chk("R5 bc entry", {21'd0, bc_ovf, bc_cnt, bc_bits}, {21'd0, 1'b0, 2'd1, 8'h02});
    chk("R5 nb entry", {21'd0, nb_ovf, nb_cnt, nb_bits}, {21'd0, 1'b0, 2'd1, 8'h02});
    chk("R5 cv entry", {21'd0, cv_ovf, cv_cnt, cv_bits}, {21'd0, 1'b0, 2'd1, 8'h02});

    // R2 second slot fills in order
    do_op(1'b0, 4'd11);
    chk("R2 cv entry", {21'd0, cv_ovf, cv_cnt, cv_bits}, {21'd0, 1'b0, 2'd2, 8'hB2});
    chk("R2 nb entry", {21'd0, nb_ovf, nb_cnt, nb_bits}, {21'd0, 1'b0, 2'd2, 8'hB2});

    // R3 duplicate read leaves everything alone
    do_op(1'b0, 4'd11);
    chk("R3 bc entry", {21'd0, bc_ovf, bc_cnt, bc_bits}, {21'd0, 1'b0, 2'd2, 8'hB2});
    chk("R3 nb no inval", {16'd0, log_nb}, 0);

    // overflow by node 6 in each mode
    do_op(1'b0, 4'd6);
    chk("R6 bc ovf, bits kept", {23'd0, bc_ovf, bc_bits}, {23'd0, 1'b1, 8'hB2});
    chk("R7 nb slot0 replaced", {23'd0, nb_ovf, nb_bits}, {23'd0, 1'b0, 8'hB6});
    chk("R7 nb displaced node", {16'd0, log_nb}, 32'h0004);
    chk("R8 cv coarse form", {23'd0, cv_ovf, cv_bits}, {23'd0, 1'b1, 8'h2A});

    do_op(1'b0, 4'd14);
    chk("R8 cv group 7 set", {24'd0, cv_bits}, 32'hAA);
    chk("R7 nb slot1 replaced", {24'd0, nb_bits}, 32'hE6);
    chk("R7 nb displaced 11", {16'd0, log_nb}, 32'h0800);
    chk("R6 bc bits kept", {24'd0, bc_bits}, 32'hB2);

    // R10 stall while a write drains
    inv_ready = 1'b0;
    issue(1'b1, 4'd15);
    chk("R10 first ids", {20'd0, bc_in, nb_in, cv_in}, {20'd0, 4'd0, 4'd6, 4'd2});
    repeat (3) @(negedge clk);
    chk("R10 held valid", {29'd0, bc_iv, nb_iv, cv_iv}, 32'b111);
    chk("R10 held ids", {20'd0, bc_in, nb_in, cv_in}, {20'd0, 4'd0, 4'd6, 4'd2});
    chk("R10 ready low", {29'd0, bc_rdy, nb_rdy, cv_rdy}, 0);
    inv_ready = 1'b1;
    wait_idle();
    @(negedge clk);
    chk("R6 bc broadcast", {16'd0, log_bc}, 32'h7FFF);
    chk("R4 nb sharers", {16'd0, log_nb}, 32'h4040);
    chk("R9 cv groups", {16'd0, log_cv}, 32'h4CCC);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule